// File: doc/BRIEF.md
# Serial 16-Point Quadrature Symbol Mapper

This block takes a serial bit stream, one bit for each cycle in which `bit_en` is high. It packs each run of four accepted bits into one symbol. Two of the four bits choose a sign and the other two choose a size. The symbol becomes a pair of signed fixed-point amplitudes, one for the in-phase rail and one for the quadrature rail. New amplitude pairs therefore appear at one quarter of the accepted bit rate. A one-cycle strobe marks every new symbol.

Each rail has four possible values: plus or minus a large level, and plus or minus a small level. The ratio of small level to large level is 0.22 to 0.821. This gives sixteen distinct output conditions.

An optional carrier stage is selected by `CARRIER_EN`. It multiplies the in-phase rail by a sampled sine and the quadrature rail by a sampled cosine, then adds the two products to form one passband sample per clock. Both carrier terms are read from one 16-entry quarter-wave table. A synchronous realign input restarts bit grouping so the framing can be locked to an external boundary.

Top module: `quad16_mapper`

## Requirements
- R1: After reset or realign, accepted bits fill `sym_bits` in this order: first bit to bit 3 (in-phase sign), second to bit 2 (in-phase size), third to bit 1 (quadrature sign), fourth to bit 0 (quadrature size).
- R2: `sym_stb` is high for exactly one cycle, in the cycle right after the clock edge that accepts the fourth bit of a group. `sym_bits`, `i_amp` and `q_amp` take their new values in that same cycle.
- R3: Between strobes, `sym_bits`, `i_amp` and `q_amp` keep their values.
- R4: Sign bit 1 gives a positive rail value and sign bit 0 gives a negative one. `sym_bits[3]` sets the sign of `i_amp` and `sym_bits[1]` sets the sign of `q_amp`.
- R5: Size bit 1 gives magnitude round(0.821·(2^(AMP_W-1)-1)), which is 1681 at the default width. Size bit 0 gives round(0.22·(2^(AMP_W-1)-1)), which is 450. `sym_bits[2]` sets the size of `i_amp` and `sym_bits[0]` sets the size of `q_amp`.
- R6: `bit_in` is ignored in any cycle where `bit_en` is low.
- R7: `align_clr` sets the bit count to zero, so the next accepted bit becomes bit 3. A bit offered in the same cycle as `align_clr` is dropped, and no strobe follows that cycle.
- R8: While reset is active, and after it is released, `sym_stb`, `sym_bits`, `i_amp`, `q_amp` and `pb_sample` are zero until the first group completes.
- R9: `pb_phase` advances by one every clock, modulo 64. `pb_sample` equals i·S(p) + q·S(p+16 mod 64), where p is `pb_phase` and S(p)=round((2^(AMP_W-1)-1)·sin((2p+1)π/64)). Here i and q are the rail values from the cycle before, because the sample takes one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial data bit |
| align_clr | input | 1 | Synchronous restart of bit grouping |
| sym_stb | output | 1 | One-cycle new-symbol strobe |
| sym_bits | output | 4 | Parallel symbol lanes {I sign, I size, Q sign, Q size} |
| i_amp | output | AMP_W | Signed in-phase amplitude |
| q_amp | output | AMP_W | Signed quadrature amplitude |
| pb_sample | output | 2·AMP_W+1 | Signed passband sample |
| pb_phase | output | 6 | Carrier phase index used for `pb_sample` |

## Verification
The strobe, the parallel lanes and both rails are due in the cycle after the edge that accepts the fourth bit. The passband sample is due one cycle after that, because it is built from the rail values held before its own register edge.

The bench drives inputs one step at a time. It updates its arithmetic model for the edge that is coming, and reads every output one nanosecond after that edge. It checks the passband sample against the rail values the model held before the step, not the values it has just computed.

The bench sweeps all sixteen symbols back to back, then sweeps them again with toggling bits in the idle gaps. It also covers realign in three positions: between bits, with a bit offered in the same cycle, and on the fourth bit. It finishes with a reset in the middle of a symbol.

// File: rtl/quad16_pkg.sv
package quad16_pkg;

  localparam int BITS_PER_SYM   = 4;
  localparam int RAIL_CNT       = 2;
  localparam int LARGE_MILLI    = 821;
  localparam int SMALL_MILLI    = 220;
  localparam int TAB_DEPTH      = 16;
  localparam int TAB_FULL_SCALE = 2047;

  // Quarter-wave samples at half-step offsets: round(2047*sin((k+0.5)*pi/32)).
  function automatic int quarter_sine(input int idx);
    case (idx)
      0:  return 100;
      1:  return 300;
      2:  return 497;
      3:  return 690;
      4:  return 875;
      5:  return 1052;
      6:  return 1219;
      7:  return 1375;
      8:  return 1517;
      9:  return 1644;
      10: return 1756;
      11: return 1850;
      12: return 1927;
      13: return 1986;
      14: return 2025;
      15: return 2045;
      default: return 0;
    endcase
  endfunction

  function automatic int level_code(input int milli, input int amp_w);
    int fs;
    fs = (1 << (amp_w - 1)) - 1;
    return (milli * fs + 500) / 1000;
  endfunction

endpackage

// File: rtl/quad16_deser.sv
module quad16_deser
  import quad16_pkg::*;
#(
  parameter int BITS = BITS_PER_SYM
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            bit_in,
  input  logic            align_clr,
  output logic            grp_done,
  output logic [BITS-1:0] grp_bits
);

  localparam int CNT_W = $clog2(BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BITS-1:0]  acc_q, acc_d;

  always_comb begin
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    grp_done = 1'b0;
    if (align_clr) begin
      cnt_d = '0;
    end else if (bit_en) begin
      acc_d[BITS-1-int'(cnt_q)] = bit_in;
      if (cnt_q == LAST) begin
        cnt_d    = '0;
        grp_done = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign grp_bits = acc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/quad16_level.sv
module quad16_level
  import quad16_pkg::*;
#(
  parameter int AMP_W = 12
) (
  input  logic                    sign_bit,
  input  logic                    size_bit,
  output logic signed [AMP_W-1:0] amp
);

  localparam int BIG   = level_code(LARGE_MILLI, AMP_W);
  localparam int SMALL = level_code(SMALL_MILLI, AMP_W);
  localparam logic signed [AMP_W-1:0] BIG_V   = AMP_W'(BIG);
  localparam logic signed [AMP_W-1:0] SMALL_V = AMP_W'(SMALL);

  logic signed [AMP_W-1:0] mag_v;

  always_comb begin
    mag_v = size_bit ? BIG_V : SMALL_V;
    amp   = sign_bit ? mag_v : -mag_v;
  end

endmodule

// File: rtl/quad16_carrier.sv
module quad16_carrier
  import quad16_pkg::*;
#(
  parameter int AMP_W = 12,
  parameter int PH_W  = $clog2(TAB_DEPTH) + 2,
  parameter int PB_W  = 2 * AMP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [AMP_W-1:0] i_amp,
  input  logic signed [AMP_W-1:0] q_amp,
  output logic signed [PB_W-1:0]  pb_sample,
  output logic [PH_W-1:0]         pb_phase
);

  localparam int QW = $clog2(TAB_DEPTH);
  localparam int FS = (1 << (AMP_W - 1)) - 1;
  localparam logic [PH_W-1:0] QUARTER = PH_W'(TAB_DEPTH);

  logic [PH_W-1:0]           ph_q, ph_d;
  logic signed [AMP_W-1:0]   sin_v, cos_v;
  logic signed [2*AMP_W-1:0] prod_i, prod_q;
  logic signed [PB_W-1:0]    pb_q, pb_d;
  logic [PH_W-1:0]           phs_q;

  function automatic logic signed [AMP_W-1:0] wave(input logic [PH_W-1:0] ph);
    logic [QW-1:0] j;
    int            mag;
    j = ph[QW-1:0];
    if (ph[QW]) j = ~j;
    mag = quarter_sine(int'(j)) * FS / TAB_FULL_SCALE;
    return ph[QW+1] ? AMP_W'(-mag) : AMP_W'(mag);
  endfunction

  always_comb begin
    sin_v  = wave(ph_q);
    cos_v  = wave(ph_q + QUARTER);
    prod_i = i_amp * sin_v;
    prod_q = q_amp * cos_v;
    pb_d   = PB_W'(prod_i) + PB_W'(prod_q);
    ph_d   = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      phs_q <= '0;
      pb_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      phs_q <= ph_q;
      pb_q  <= pb_d;
    end
  end

  assign pb_sample = pb_q;
  assign pb_phase  = phs_q;

endmodule

// File: rtl/quad16_mapper.sv
module quad16_mapper
  import quad16_pkg::*;
#(
  parameter  int AMP_W      = 12,
  parameter  bit CARRIER_EN = 1'b1,
  localparam int PB_W       = 2 * AMP_W + 1,
  localparam int PH_W       = $clog2(TAB_DEPTH) + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_en,
  input  logic                    bit_in,
  input  logic                    align_clr,
  output logic                    sym_stb,
  output logic [BITS_PER_SYM-1:0] sym_bits,
  output logic signed [AMP_W-1:0] i_amp,
  output logic signed [AMP_W-1:0] q_amp,
  output logic signed [PB_W-1:0]  pb_sample,
  output logic [PH_W-1:0]         pb_phase
);

  // reset release synchronizer
  logic [1:0] rsync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  logic                    grp_done;
  logic [BITS_PER_SYM-1:0] grp_bits;

  quad16_deser #(.BITS(BITS_PER_SYM)) u_deser (
    .clk      (clk),
    .rst_n    (rst_q),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .align_clr(align_clr),
    .grp_done (grp_done),
    .grp_bits (grp_bits)
  );

  // rail 0 = in-phase (bits 3,2), rail 1 = quadrature (bits 1,0)
  logic signed [AMP_W-1:0] lvl [RAIL_CNT];

  for (genvar g = 0; g < RAIL_CNT; g++) begin : g_rail
    quad16_level #(.AMP_W(AMP_W)) u_level (
      .sign_bit(grp_bits[BITS_PER_SYM-1-2*g]),
      .size_bit(grp_bits[BITS_PER_SYM-2-2*g]),
      .amp     (lvl[g])
    );
  end

  logic                    stb_q, stb_d;
  logic [BITS_PER_SYM-1:0] bits_q, bits_d;
  logic signed [AMP_W-1:0] i_q, i_d, q_q, q_d;

  always_comb begin
    stb_d  = grp_done;
    bits_d = bits_q;
    i_d    = i_q;
    q_d    = q_q;
    if (grp_done) begin
      bits_d = grp_bits;
      i_d    = lvl[0];
      q_d    = lvl[1];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      stb_q  <= 1'b0;
      bits_q <= '0;
      i_q    <= '0;
      q_q    <= '0;
    end else begin
      stb_q  <= stb_d;
      bits_q <= bits_d;
      i_q    <= i_d;
      q_q    <= q_d;
    end
  end

  assign sym_stb  = stb_q;
  assign sym_bits = bits_q;
  assign i_amp    = i_q;
  assign q_amp    = q_q;

  if (CARRIER_EN) begin : g_carrier
    quad16_carrier #(.AMP_W(AMP_W), .PH_W(PH_W), .PB_W(PB_W)) u_carrier (
      .clk      (clk),
      .rst_n    (rst_q),
      .i_amp    (i_q),
      .q_amp    (q_q),
      .pb_sample(pb_sample),
      .pb_phase (pb_phase)
    );
  end else begin : g_no_carrier
    assign pb_sample = '0;
    assign pb_phase  = '0;
  end

endmodule

// File: rtl/quad16_mapper_chk.sv
module quad16_mapper_chk
  import quad16_pkg::*;
#(
  parameter int AMP_W = 12
) (
  input logic                    clk,
  input logic                    rst_q,
  input logic                    bit_en,
  input logic                    align_clr,
  input logic                    sym_stb,
  input logic [BITS_PER_SYM-1:0] sym_bits,
  input logic signed [AMP_W-1:0] i_amp,
  input logic signed [AMP_W-1:0] q_amp
);

  localparam logic signed [AMP_W-1:0] BIG_P   = AMP_W'(level_code(LARGE_MILLI, AMP_W));
  localparam logic signed [AMP_W-1:0] SMALL_P = AMP_W'(level_code(SMALL_MILLI, AMP_W));
  localparam logic signed [AMP_W-1:0] BIG_N   = -BIG_P;
  localparam logic signed [AMP_W-1:0] SMALL_N = -SMALL_P;

  AST_STB_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_q)
    sym_stb |-> ($past(bit_en) && !$past(align_clr))); // R2

  AST_CLR_NO_STB: assert property (@(posedge clk) disable iff (!rst_q)
    align_clr |=> !sym_stb); // R7

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_q)
    !sym_stb |-> ($stable(i_amp) && $stable(q_amp) && $stable(sym_bits))); // R3

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_q)
    sym_stb |-> ((i_amp[AMP_W-1] != sym_bits[3]) && (q_amp[AMP_W-1] != sym_bits[1]))); // R4

  AST_SIZE_MATCH: assert property (@(posedge clk) disable iff (!rst_q)
    sym_stb |-> (((i_amp == BIG_P) || (i_amp == BIG_N)) == sym_bits[2]) &&
                (((q_amp == BIG_P) || (q_amp == BIG_N)) == sym_bits[0])); // R5

  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_q)
    sym_stb |-> ((i_amp == BIG_P) || (i_amp == BIG_N) || (i_amp == SMALL_P) || (i_amp == SMALL_N)) &&
                ((q_amp == BIG_P) || (q_amp == BIG_N) || (q_amp == SMALL_P) || (q_amp == SMALL_N))); // R5

endmodule

bind quad16_mapper quad16_mapper_chk #(.AMP_W(AMP_W)) u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .bit_en   (bit_en),
  .align_clr(align_clr),
  .sym_stb  (sym_stb),
  .sym_bits (sym_bits),
  .i_amp    (i_amp),
  .q_amp    (q_amp)
);

// File: tb/test_quad16_mapper.sv
`timescale 1ns/1ps
module test_quad16_mapper;

  localparam int AMP_W = 12;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bit_en, bit_in, align_clr;
  logic sym_stb;
  logic [3:0] sym_bits;
  logic signed [AMP_W-1:0] i_amp, q_amp;
  logic signed [2*AMP_W:0] pb_sample;
  logic [5:0] pb_phase;

  quad16_mapper #(.AMP_W(AMP_W), .CARRIER_EN(1'b1)) i_quad16_mapper (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .align_clr(align_clr),
    .sym_stb(sym_stb), .sym_bits(sym_bits), .i_amp(i_amp), .q_amp(q_amp),
    .pb_sample(pb_sample), .pb_phase(pb_phase)
  );

  int n_chk = 0, n_fail = 0;
  int m_cnt, m_i, m_q, p_i, p_q, m_ph;
  logic [3:0] m_acc, m_bits;
  logic m_stb;

  function automatic int amp(input logic s, input logic m);
    int v;
    v = m ? $rtoi(0.821 * 2047.0 + 0.5) : $rtoi(0.22 * 2047.0 + 0.5);
    return s ? v : -v;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; align_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(sym_stb == 1'b0, "R8", "stb in reset", sym_stb, 0);
    chk(i_amp == 0 && q_amp == 0, "R8", "rails in reset", i_amp, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(sym_stb == 1'b0, "R8", "stb after reset", sym_stb, 0);
    chk(sym_bits == 4'd0, "R8", "bits after reset", sym_bits, 0);
    chk(i_amp == 0, "R8", "i rail after reset", i_amp, 0);
    chk(q_amp == 0, "R8", "q rail after reset", q_amp, 0);
    chk(pb_sample == 0, "R8", "passband after reset", pb_sample, 0);
    m_cnt = 0; m_i = 0; m_q = 0; m_bits = 4'd0; m_acc = 4'd0;
    m_ph = int'(pb_phase);
  endtask

  task automatic step(input logic en, input logic b, input logic clr);
    real e, ang;
    longint tol;
    string rq;
    @(negedge clk);
    bit_en = en; bit_in = b; align_clr = clr;
    p_i = m_i; p_q = m_q; m_stb = 1'b0;
    if (clr) m_cnt = 0;
    else if (en) begin
      m_acc[3-m_cnt] = b;
      if (m_cnt == 3) begin
        m_cnt = 0; m_stb = 1'b1; m_bits = m_acc;
        m_i = amp(m_acc[3], m_acc[2]);
        m_q = amp(m_acc[1], m_acc[0]);
      end else m_cnt++;
    end
    @(posedge clk);
    #1;
    rq = clr ? "R7" : (m_stb ? "R2" : (en ? "R3" : "R6"));
    chk(sym_stb == m_stb, rq, "strobe", sym_stb, m_stb);
    chk(sym_bits == m_bits, m_stb ? "R1" : rq, "lanes", sym_bits, m_bits);
    chk(int'(i_amp) == m_i, m_stb ? "R4" : rq, "i rail", i_amp, m_i);
    chk(int'(q_amp) == m_q, m_stb ? "R5" : rq, "q rail", q_amp, m_q);
    m_ph = (m_ph + 1) % 64;
    chk(int'(pb_phase) == m_ph, "R9", "phase step", pb_phase, m_ph);
    ang = (2.0 * pb_phase + 1.0) * PI / 64.0;
    e = p_i * 2047.0 * $sin(ang) + p_q * 2047.0 * $cos(ang);
    tol = (p_i < 0 ? -p_i : p_i) + (p_q < 0 ? -p_q : p_q) + 1;
    chk(($itor(pb_sample) - e) <= tol && (e - $itor(pb_sample)) <= tol,
        "R9", "passband", pb_sample, $rtoi(e));
  endtask

  initial begin
    #1ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1 R2 R4 R5: all sixteen symbols back to back
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 4; k++) step(1'b1, s[3-k], 1'b0);
    // R3 R6: descending sweep with toggling ignored bits in gaps
    for (int s = 15; s >= 0; s--)
      for (int k = 0; k < 4; k++) begin
        step(1'b1, s[3-k], 1'b0);
        step(1'b0, ~s[3-k], 1'b0);
        step(1'b0, s[3-k], 1'b0);
      end
    // R7: realign between bits
    step(1'b1, 1'b1, 1'b0); step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) step(1'b1, k == 1 || k == 2, 1'b0);
    // R7: bit offered with realign is dropped
    step(1'b1, 1'b1, 1'b0); step(1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) step(1'b1, k == 0 || k == 3, 1'b0);
    // R7: realign on the fourth bit gives no strobe
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) step(1'b1, k[0], 1'b0);
    // R8: reset in the middle of a symbol
    step(1'b1, 1'b1, 1'b0); step(1'b1, 1'b1, 1'b0);
    do_reset();
    for (int k = 0; k < 4; k++) step(1'b1, k != 2, 1'b0);
    repeat (3) step(1'b0, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule